// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits beside the priority core of an 8-level interrupt controller. It produces the bytes that the controller places on the data bus during the processor's interrupt-acknowledge cycles. It runs in one of two sequence modes:

- **Two-cycle mode.** The first strobe returns a filler byte. The second strobe returns the vector number.
- **Three-cycle mode.** The first strobe returns a subroutine-call opcode. The second strobe returns the low address byte, which depends on the vector interval. The third strobe returns the high address byte.

Along the way the block tells the core what to do. On the first strobe it asks the core to mark the level in service, and it freezes the resolved level for the rest of the sequence. On the last strobe it asks the core to clear the pending flag, and it can request an automatic non-specific end-of-interrupt, with or without rotation. When the sequence ends it releases the frozen level so the core can resolve priority again.

Levels marked as cascaded take their later bytes from a slave-data input. An acknowledge that arrives with nothing pending is served as spurious level 7 and has no side effects.

Top module: `intack_seq`

## Requirements
- R1: While reset is held and straight after it, ackDataValid, isrSet, pendClear, eoiPulse, rotatePulse, releasePulse, resolveFrozen and slaveSel are all 0.
- R2: The first strobe of a sequence returns 0xFF when cfgTwoCycle=1 and 0xCD when cfgTwoCycle=0. It pulses isrSet with isrLevel equal to irqLevel when irqPending=1, and it raises resolveFrozen.
- R3: In two-cycle mode the second strobe returns {cfgVectorBase[7:3], level} and ends the sequence.
- R4: In three-cycle mode with cfgInterval4=1 the second strobe returns {cfgCallHigh[2:0], level, 2'b00}.
- R5: In three-cycle mode with cfgInterval4=0 the second strobe returns {cfgCallHigh[2:1], level, 3'b000}; cfgCallHigh[0] has no effect.
- R6: In three-cycle mode the third strobe returns cfgVectorBase. In either mode the last strobe of a non-spurious sequence pulses pendClear.
- R7: The last strobe pulses eoiPulse when cfgAutoEoi was 1 at the first strobe and the sequence is not spurious. rotatePulse pulses with it when autoRotate=1.
- R8: The last strobe pulses releasePulse and drops resolveFrozen. The next strobe begins a new sequence.
- R9: The level used for every byte and for isrLevel is the one captured at the first strobe; later changes on irqLevel have no effect within the sequence.
- R10: When irqPending=1 and cfgCascadeMap[level]=1, every byte after the first is slaveData and slaveSel is 1 with it. The first byte is still generated locally.
- R11: A first strobe with irqPending=0 uses level 7. Such a sequence pulses neither isrSet, pendClear nor eoiPulse, and ignores the cascade map.
- R12: The sequence length is fixed by cfgTwoCycle at the first strobe; a change during the sequence has no effect until the next one.
- R13: Every strobe gives exactly one cycle of ackDataValid, in the cycle after it; data and pulses update at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ackStrobe | input | 1 | One acknowledge cycle, one clock wide |
| cfgTwoCycle | input | 1 | 1 = two-cycle processor mode, 0 = three-cycle call mode |
| cfgAutoEoi | input | 1 | Automatic end-of-interrupt on the last strobe |
| cfgInterval4 | input | 1 | 1 = 4-byte vector interval, 0 = 8-byte |
| cfgCallHigh | input | 3 | Upper bits of the call low-address byte |
| cfgVectorBase | input | 8 | Vector base / call high-address byte |
| cfgCascadeMap | input | 8 | Per level: 1 = level fed by a slave controller |
| autoRotate | input | 1 | Rotate priority together with the automatic EOI |
| irqPending | input | 1 | Core has a resolved pending interrupt |
| irqLevel | input | 3 | Level resolved by the core |
| slaveData | input | 8 | Byte supplied by the addressed slave |
| ackData | output | 8 | Byte for the current acknowledge cycle |
| ackDataValid | output | 1 | ackData is valid this cycle |
| isrSet | output | 1 | Set in-service bit for isrLevel |
| isrLevel | output | 3 | Level frozen for this sequence |
| pendClear | output | 1 | Clear the core's pending flag |
| eoiPulse | output | 1 | Automatic non-specific end-of-interrupt |
| rotatePulse | output | 1 | Rotate priority along with the EOI |
| releasePulse | output | 1 | Sequence done, re-resolve pending state |
| resolveFrozen | output | 1 | Priority resolution held during the sequence |
| slaveSel | output | 1 | ackData came from slaveData |

## Verification
The checker watches the properties that hold in every cycle:

- Each strobe yields exactly one valid cycle.
- EOI, rotation and pending-clear occur only alongside the release pulse.
- The release pulse always leaves resolution unfrozen.
- The frozen level never moves while a sequence is open.
- An in-service request never coincides with the release.

Only the bench scenarios can show the values of the bytes themselves: the opcode and filler, the two interval encodings, cascade pass-through, spurious handling, and the fact that changes to the mode or level in mid-sequence are ignored.

// File: rtl/intack_pkg.sv
package intack_pkg;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 3;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int HI_W   = DATA_W - LVL_W - 2;
  localparam logic [DATA_W-1:0] FILLER_BYTE = '1;
  localparam logic [DATA_W-1:0] CALL_OPCODE = 8'hCD;
  localparam logic [LVL_W-1:0]  SPURIOUS_LVL = '1;

  // Strobes from the sequence control to the byte datapath
  typedef struct packed {
    logic first;
    logic second;
    logic third;
    logic last;
  } ackStep_t;
endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ackStrobe,
  input  logic     cfgTwoCycle,
  output ackStep_t step
);
  localparam int PH_W = 2;
  localparam logic [PH_W-1:0] PH_IDLE = 2'd0;
  localparam logic [PH_W-1:0] PH_MID  = 2'd1;
  localparam logic [PH_W-1:0] PH_TAIL = 2'd2;

  logic [PH_W-1:0] phase;
  logic            twoModeQ;
  logic            effTwo;

  // Mode is taken live on the first strobe, then held for the sequence
  assign effTwo = (phase == PH_IDLE) ? cfgTwoCycle : twoModeQ;

  always_comb begin
    step.first  = ackStrobe && (phase == PH_IDLE);
    step.second = ackStrobe && (phase == PH_MID);
    step.third  = ackStrobe && (phase == PH_TAIL);
    step.last   = (step.second && effTwo) || step.third;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      twoModeQ <= 1'b0;
    end else if (ackStrobe) begin
      if (step.first) twoModeQ <= cfgTwoCycle;
      phase <= step.last ? PH_IDLE : phase + 1'b1;
    end
  end
endmodule

// File: rtl/intack_dp.sv
module intack_dp
  import intack_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ackStep_t           step,
  input  logic               cfgTwoCycle,
  input  logic               cfgAutoEoi,
  input  logic               cfgInterval4,
  input  logic [HI_W-1:0]    cfgCallHigh,
  input  logic [DATA_W-1:0]  cfgVectorBase,
  input  logic [NUM_LVL-1:0] cfgCascadeMap,
  input  logic               autoRotate,
  input  logic               irqPending,
  input  logic [LVL_W-1:0]   irqLevel,
  input  logic [DATA_W-1:0]  slaveData,
  output logic [DATA_W-1:0]  ackData,
  output logic               ackDataValid,
  output logic               isrSet,
  output logic [LVL_W-1:0]   isrLevel,
  output logic               pendClear,
  output logic               eoiPulse,
  output logic               rotatePulse,
  output logic               releasePulse,
  output logic               resolveFrozen,
  output logic               slaveSel
);
  logic [LVL_W-1:0]  lvlQ;
  logic              spurQ, cascQ, twoQ, aeoiQ;
  logic [LVL_W-1:0]  startLvl;
  logic [DATA_W-1:0] byteNext;
  logic [DATA_W-1:0] callLow;

  assign startLvl = irqPending ? irqLevel : SPURIOUS_LVL;

  // Low address byte of the call, interval picks how far the level shifts
  always_comb begin
    if (cfgInterval4) callLow = {cfgCallHigh, lvlQ, 2'b00};
    else              callLow = {cfgCallHigh[HI_W-1:1], lvlQ, 3'b000};
  end

  always_comb begin
    if (step.first)
      byteNext = cfgTwoCycle ? FILLER_BYTE : CALL_OPCODE;
    else if (cascQ)
      byteNext = slaveData;
    else if (step.second)
      byteNext = twoQ ? {cfgVectorBase[DATA_W-1:LVL_W], lvlQ} : callLow;
    else
      byteNext = cfgVectorBase;
  end

  assign isrLevel = lvlQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ <= '0; spurQ <= 1'b0; cascQ <= 1'b0; twoQ <= 1'b0; aeoiQ <= 1'b0;
      ackData <= '0; ackDataValid <= 1'b0; isrSet <= 1'b0; pendClear <= 1'b0;
      eoiPulse <= 1'b0; rotatePulse <= 1'b0; releasePulse <= 1'b0;
      resolveFrozen <= 1'b0; slaveSel <= 1'b0;
    end else begin
      ackDataValid <= step.first | step.second | step.third;
      isrSet       <= 1'b0;
      pendClear    <= 1'b0;
      eoiPulse     <= 1'b0;
      rotatePulse  <= 1'b0;
      releasePulse <= 1'b0;
      slaveSel     <= 1'b0;
      if (step.first | step.second | step.third) ackData <= byteNext;
      if (step.first) begin
        lvlQ          <= startLvl;
        spurQ         <= !irqPending;
        cascQ         <= irqPending && cfgCascadeMap[startLvl];
        twoQ          <= cfgTwoCycle;
        aeoiQ         <= cfgAutoEoi;
        isrSet        <= irqPending;
        resolveFrozen <= 1'b1;
      end
      if (step.second | step.third) slaveSel <= cascQ;
      if (step.last) begin
        releasePulse  <= 1'b1;
        resolveFrozen <= 1'b0;
        pendClear     <= !spurQ;
        eoiPulse      <= aeoiQ && !spurQ;
        rotatePulse   <= aeoiQ && !spurQ && autoRotate;
      end
    end
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackStrobe,
  input  logic               cfgTwoCycle,
  input  logic               cfgAutoEoi,
  input  logic               cfgInterval4,
  input  logic [HI_W-1:0]    cfgCallHigh,
  input  logic [DATA_W-1:0]  cfgVectorBase,
  input  logic [NUM_LVL-1:0] cfgCascadeMap,
  input  logic               autoRotate,
  input  logic               irqPending,
  input  logic [LVL_W-1:0]   irqLevel,
  input  logic [DATA_W-1:0]  slaveData,
  output logic [DATA_W-1:0]  ackData,
  output logic               ackDataValid,
  output logic               isrSet,
  output logic [LVL_W-1:0]   isrLevel,
  output logic               pendClear,
  output logic               eoiPulse,
  output logic               rotatePulse,
  output logic               releasePulse,
  output logic               resolveFrozen,
  output logic               slaveSel
);
  ackStep_t step;

  intack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe),
    .cfgTwoCycle(cfgTwoCycle), .step(step)
  );

  intack_dp u_dp (
    .clk(clk), .rstN(rstN), .step(step),
    .cfgTwoCycle(cfgTwoCycle), .cfgAutoEoi(cfgAutoEoi),
    .cfgInterval4(cfgInterval4), .cfgCallHigh(cfgCallHigh),
    .cfgVectorBase(cfgVectorBase), .cfgCascadeMap(cfgCascadeMap),
    .autoRotate(autoRotate), .irqPending(irqPending), .irqLevel(irqLevel),
    .slaveData(slaveData), .ackData(ackData), .ackDataValid(ackDataValid),
    .isrSet(isrSet), .isrLevel(isrLevel), .pendClear(pendClear),
    .eoiPulse(eoiPulse), .rotatePulse(rotatePulse),
    .releasePulse(releasePulse), .resolveFrozen(resolveFrozen),
    .slaveSel(slaveSel)
  );
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk
  import intack_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ackStrobe,
  input logic              ackDataValid,
  input logic              isrSet,
  input logic [LVL_W-1:0]  isrLevel,
  input logic              pendClear,
  input logic              eoiPulse,
  input logic              rotatePulse,
  input logic              releasePulse,
  input logic              resolveFrozen,
  input logic              slaveSel
);
  p_valid_follows_r13: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> ackDataValid);
  p_no_stray_valid_r13: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> !ackDataValid);
  p_eoi_on_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    eoiPulse |-> releasePulse);
  p_rotate_needs_eoi_r7: assert property (@(posedge clk) disable iff (!rstN)
    rotatePulse |-> eoiPulse);
  p_clear_on_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    pendClear |-> releasePulse);
  p_release_unfreezes_r8: assert property (@(posedge clk) disable iff (!rstN)
    releasePulse |-> !resolveFrozen);
  p_isr_first_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    isrSet |-> (resolveFrozen && ackDataValid && !releasePulse));
  p_level_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resolveFrozen && $past(resolveFrozen)) |-> $stable(isrLevel));
  p_slave_with_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    slaveSel |-> (ackDataValid && !isrSet));
endmodule

bind intack_seq intack_seq_chk u_chk (.*);

// File: tb/intack_seq_tb.sv
module intack_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ackStrobe = 1'b0;
  logic       cfgTwoCycle = 1'b0, cfgAutoEoi = 1'b0, cfgInterval4 = 1'b0;
  logic [2:0] cfgCallHigh = '0;
  logic [7:0] cfgVectorBase = '0, cfgCascadeMap = '0, slaveData = '0;
  logic       autoRotate = 1'b0, irqPending = 1'b0;
  logic [2:0] irqLevel = '0;
  logic [7:0] ackData;
  logic       ackDataValid, isrSet, pendClear, eoiPulse, rotatePulse;
  logic       releasePulse, resolveFrozen, slaveSel;
  logic [2:0] isrLevel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  intack_seq u_dut (.*);

  typedef struct packed {
    logic two, aeoi, rot, pend;
    logic [2:0] lvl;
    logic int4;
    logic [2:0] hi;
    logic [7:0] base, casc, slave, e1, e2;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b1,3'd5,1'b0,3'b000,8'h08,8'h00,8'h00,8'h0D,8'h00},
    '{1'b1,1'b1,1'b1,1'b1,3'd3,1'b0,3'b000,8'h70,8'h00,8'h00,8'h73,8'h00},
    '{1'b0,1'b0,1'b0,1'b1,3'd6,1'b1,3'b101,8'h12,8'h00,8'h00,8'hB8,8'h12},
    '{1'b0,1'b1,1'b0,1'b1,3'd2,1'b0,3'b111,8'h34,8'h00,8'h00,8'hD0,8'h34},
    '{1'b1,1'b0,1'b0,1'b1,3'd2,1'b0,3'b000,8'h08,8'h04,8'h5A,8'h5A,8'h00},
    '{1'b0,1'b1,1'b0,1'b0,3'd3,1'b1,3'b000,8'h20,8'h00,8'h00,8'h1C,8'h20},
    '{1'b1,1'b0,1'b0,1'b0,3'd4,1'b0,3'b000,8'h48,8'h80,8'h00,8'h4F,8'h00},
    '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,3'b000,8'h66,8'h02,8'h99,8'h99,8'h99}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one strobe; sample after the edge that registers it
  task automatic strobe();
    @(negedge clk) ackStrobe = 1'b1;
    @(negedge clk) ackStrobe = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    logic casc;
    int n;
    @(negedge clk);
    cfgTwoCycle = v.two; cfgAutoEoi = v.aeoi; autoRotate = v.rot;
    irqPending = v.pend; irqLevel = v.lvl; cfgInterval4 = v.int4;
    cfgCallHigh = v.hi; cfgVectorBase = v.base; cfgCascadeMap = v.casc;
    slaveData = v.slave;
    casc = v.pend && v.casc[v.lvl];
    n = v.two ? 2 : 3;
    strobe();
    chk("R2 first byte", ackData, v.two ? 8'hFF : 8'hCD);
    chk("R13 valid", {7'd0, ackDataValid}, 8'd1);
    chk("R2/R11 isrSet", {7'd0, isrSet}, {7'd0, v.pend});
    chk("R11 level", {5'd0, isrLevel}, {5'd0, v.pend ? v.lvl : 3'd7});
    chk("R2 frozen", {7'd0, resolveFrozen}, 8'd1);
    for (int k = 1; k < n; k++) begin
      strobe();
      chk(k == 1 ? (v.two ? "R3 byte2" : (v.int4 ? "R4 byte2" : "R5 byte2"))
                 : "R6 byte3", ackData, k == 1 ? v.e1 : v.e2);
      chk("R10 slaveSel", {7'd0, slaveSel}, {7'd0, casc});
      chk("R8 release", {7'd0, releasePulse}, {7'd0, k == n - 1});
    end
    chk("R6 pendClear", {7'd0, pendClear}, {7'd0, v.pend});
    chk("R7 eoi", {7'd0, eoiPulse}, {7'd0, v.aeoi & v.pend});
    chk("R7 rotate", {7'd0, rotatePulse}, {7'd0, v.aeoi & v.pend & v.rot});
    chk("R8 unfrozen", {7'd0, resolveFrozen}, 8'd0);
    @(negedge clk);
    chk("R13 valid one cycle", {7'd0, ackDataValid}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {7'd0, ackDataValid}, 8'd0);
    chk("R1 reset pulses", {2'd0, isrSet, pendClear, eoiPulse, rotatePulse,
        releasePulse, slaveSel}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset frozen", {7'd0, resolveFrozen}, 8'd0);

    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // R9: level moves mid-sequence, interval 4, high bits 101, level 4
    @(negedge clk);
    cfgTwoCycle = 1'b0; cfgInterval4 = 1'b1; cfgCallHigh = 3'b101;
    cfgCascadeMap = 8'h00; irqPending = 1'b1; irqLevel = 3'd4;
    strobe();
    irqLevel = 3'd1;
    strobe();
    chk("R9 byte uses frozen level", ackData, 8'hB0);
    chk("R9 isrLevel held", {5'd0, isrLevel}, 8'd4);
    strobe();

    // R12: mode flips to three-cycle after first strobe of a two-cycle run
    cfgTwoCycle = 1'b1; cfgVectorBase = 8'h08; irqLevel = 3'd2;
    strobe();
    cfgTwoCycle = 1'b0;
    strobe();
    chk("R12 two-cycle byte kept", ackData, 8'h0A);
    chk("R12 ends after two", {7'd0, releasePulse}, 8'd1);
    strobe();
    chk("R12 new sequence uses new mode", ackData, 8'hCD);
    strobe();
    strobe();
    chk("R8 three-cycle ends", {7'd0, releasePulse}, 8'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule